// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation converter. A start pulse opens an acquisition window, during which the analog front end tracks the input. One isolation cycle then holds the sample before any trial runs. The block next performs a binary search from the most significant bit down. For each bit it drives a grounding phase and a compare phase that never overlap. It presents the trial code to the DAC and raises a strobe at the point where the comparator decision is taken.

When the last bit has been decided, the code is latched into a result register. A one-cycle done pulse marks it, and busy falls in the same cycle. A power-down request is honoured only between conversions. It then drops the enable for the converter core and its local clock.

The capacitor array, comparator and reference sit outside this block. The comparator output arrives as a plain logic input that is sampled at the strobe.

Top module: `sar_sequencer`

## Requirements
- R1: While reset is held and right after it is released, busy, done, acquire, both phase enables, the strobe, the DAC code and the result are all zero.
- R2: Starting in idle, acquire is high for exactly ACQ_CYC cycles, beginning in the first busy cycle. The cycle after acquire falls has acquire and both phase enables low.
- R3: The grounding phase and the compare phase are never high in the same cycle. Every switch from one to the other passes through at least one cycle with both low.
- R4: The first trial code is the MSB alone (0x80). During the trial for bit b, the DAC code carries the decided bits above b, bit b at 1 and all bits below b at 0.
- R5: The strobe is high only in the last cycle of a compare phase, exactly W times per conversion. At the strobe, the trial bit is kept at 1 if the comparator input is high and cleared to 0 otherwise.
- R6: With a comparator that reports input code >= DAC code, the result equals the input code for every code 0..255. The result changes only in the cycle in which done is high.
- R7: Busy stays high for exactly ACQ_CYC + W*(2*DEAD_CYC + 2*PH_CYC) cycles (52 with the defaults). Done is high for a single cycle, and that cycle is the first one in which busy is low.
- R8: A start pulse that arrives while busy, including in the last busy cycle, changes neither the length of the conversion nor its result, and it does not begin a new conversion.
- R9: The core enable is low when the block is idle with the power-down request high. It is high while busy, whatever the request is, and high whenever the request is low.
- R10: While idle, the DAC code is zero and acquire and both phase enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, taken only when idle |
| cmp_i | input | 1 | Comparator result, high when the input is at or above the DAC level |
| pdn_mode_i | input | 1 | Request to power the core down between conversions |
| dac_code_o | output | WIDTH | Trial code applied to the DAC |
| ph1_o | output | 1 | Grounding phase enable |
| ph2_o | output | 1 | Compare phase enable |
| acq_o | output | 1 | Acquisition (track) enable |
| sample_o | output | 1 | Comparator decision strobe |
| result_o | output | WIDTH | Last completed conversion code |
| done_o | output | 1 | One-cycle result-valid pulse |
| busy_o | output | 1 | Conversion in progress |
| core_en_o | output | 1 | Power and clock enable for the converter core |

## Verification
The bound assertions check on every cycle that the phases never overlap and keep a dead cycle between them. They also check that the strobe lies inside the compare phase, that the outputs stay quiet while idle, that done is a single-cycle pulse tied to the fall of busy, that the result holds between completions, and that the core enable follows the power-down request. Other behaviour needs the bench's scenarios: the exact result for all 256 input codes, the trial code seen at each strobe, the conversion length and acquisition width, and the absence of any effect from a start pulse that lands during a conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACQ  = 3'd1,
    ST_GAPA = 3'd2,
    ST_PH1  = 3'd3,
    ST_GAPB = 3'd4,
    ST_PH2  = 3'd5
  } sar_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sar_phase_timer.sv
module sar_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int W        = 8,
  parameter int ACQ_CYC  = 4,
  parameter int PH_CYC   = 2,
  parameter int DEAD_CYC = 1,
  parameter int CNT_W    = 2,
  parameter int BIT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tmr_zero_i,
  output sar_state_e       state_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             init_o,
  output logic             decide_o,
  output logic [BIT_W-1:0] bit_idx_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ACQ_LD  = CNT_W'(ACQ_CYC - 1);
  localparam logic [CNT_W-1:0] PH_LD   = CNT_W'(PH_CYC - 1);
  localparam logic [CNT_W-1:0] DEAD_LD = CNT_W'(DEAD_CYC - 1);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(W - 1);

  sar_state_e       state_q, state_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             done_q, done_d;
  logic             bit_en;

  // next-state logic
  always_comb begin
    state_d    = state_q;
    bit_d      = bit_q;
    bit_en     = 1'b0;
    done_d     = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    init_o     = 1'b0;
    decide_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_ACQ;
          tmr_load_o = 1'b1;
          tmr_val_o  = ACQ_LD;
          init_o     = 1'b1;
          bit_d      = TOP_BIT;
          bit_en     = 1'b1;
        end
      end
      ST_ACQ: begin
        if (tmr_zero_i) begin
          state_d    = ST_GAPA;
          tmr_load_o = 1'b1;
          tmr_val_o  = DEAD_LD;
        end
      end
      ST_GAPA: begin
        if (tmr_zero_i) begin
          state_d    = ST_PH1;
          tmr_load_o = 1'b1;
          tmr_val_o  = PH_LD;
        end
      end
      ST_PH1: begin
        if (tmr_zero_i) begin
          state_d    = ST_GAPB;
          tmr_load_o = 1'b1;
          tmr_val_o  = DEAD_LD;
        end
      end
      ST_GAPB: begin
        if (tmr_zero_i) begin
          state_d    = ST_PH2;
          tmr_load_o = 1'b1;
          tmr_val_o  = PH_LD;
        end
      end
      ST_PH2: begin
        if (tmr_zero_i) begin
          decide_o = 1'b1;
          if (bit_q == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d    = ST_GAPA;
            tmr_load_o = 1'b1;
            tmr_val_o  = DEAD_LD;
            bit_d      = bit_q - 1'b1;
            bit_en     = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
    end else if (bit_en) begin
      bit_q <= bit_d;
    end
  end

  assign state_o   = state_q;
  assign bit_idx_o = bit_q;
  assign done_o    = done_q;

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int W     = 8,
  parameter int BIT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             decide_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic             cmp_i,
  output logic [W-1:0]     trial_o,
  output logic [W-1:0]     result_o
);

  logic [W-1:0] trial_q, trial_d;
  logic [W-1:0] result_q;
  logic         trial_en, result_en;

  // per-bit next value: decided bit takes the comparator, the bit below it is raised
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic hit_here;
    logic hit_above;
    assign hit_here = decide_i && (bit_idx_i == BIT_W'(i));
    if (i < W - 1) begin : g_low
      assign hit_above = decide_i && (bit_idx_i == BIT_W'(i + 1));
    end else begin : g_top
      assign hit_above = 1'b0;
    end
    always_comb begin
      if (init_i) begin
        trial_d[i] = (i == W - 1);
      end else if (hit_here) begin
        trial_d[i] = cmp_i;
      end else if (hit_above) begin
        trial_d[i] = 1'b1;
      end else begin
        trial_d[i] = trial_q[i];
      end
    end
  end

  assign trial_en  = init_i || decide_i;
  assign result_en = decide_i && (bit_idx_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
    end else if (trial_en) begin
      trial_q <= trial_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (result_en) begin
      result_q <= trial_d;
    end
  end

  assign trial_o  = trial_q;
  assign result_o = result_q;

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int ACQ_CYC  = 4,
  parameter int PH_CYC   = 2,
  parameter int DEAD_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic             pdn_mode_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             ph1_o,
  output logic             ph2_o,
  output logic             acq_o,
  output logic             sample_o,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             core_en_o
);

  localparam int MAX_DUR = max3(ACQ_CYC, PH_CYC, DEAD_CYC);
  localparam int CNT_W   = (MAX_DUR < 2) ? 1 : $clog2(MAX_DUR);
  localparam int BIT_W   = (WIDTH < 2) ? 1 : $clog2(WIDTH);

  sar_state_e       state;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             init, decide;
  logic [BIT_W-1:0] bit_idx;
  logic [WIDTH-1:0] trial;

  sar_ctrl #(
    .W(WIDTH), .ACQ_CYC(ACQ_CYC), .PH_CYC(PH_CYC), .DEAD_CYC(DEAD_CYC),
    .CNT_W(CNT_W), .BIT_W(BIT_W)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tmr_zero_i (tmr_zero),
    .state_o    (state),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .init_o     (init),
    .decide_o   (decide),
    .bit_idx_o  (bit_idx),
    .done_o     (done_o)
  );

  sar_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sar_trial_reg #(.W(WIDTH), .BIT_W(BIT_W)) i_trial (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (init),
    .decide_i  (decide),
    .bit_idx_i (bit_idx),
    .cmp_i     (cmp_i),
    .trial_o   (trial),
    .result_o  (result_o)
  );

  assign busy_o     = (state != ST_IDLE);
  assign acq_o      = (state == ST_ACQ);
  assign ph1_o      = (state == ST_PH1);
  assign ph2_o      = (state == ST_PH2);
  assign sample_o   = decide;
  assign dac_code_o = busy_o ? trial : '0;
  assign core_en_o  = busy_o || !pdn_mode_i;

endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pdn_mode_i,
  input logic [WIDTH-1:0] dac_code_o,
  input logic             ph1_o,
  input logic             ph2_o,
  input logic             acq_o,
  input logic             sample_o,
  input logic [WIDTH-1:0] result_o,
  input logic             done_o,
  input logic             busy_o,
  input logic             core_en_o
);

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph1_o && ph2_o));
  p_dead_after_ph1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph1_o) |-> !ph2_o);
  p_dead_after_ph2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph2_o) |-> !ph1_o);
  p_isolate_after_acq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acq_o) |-> (busy_o && !ph1_o && !ph2_o));
  p_strobe_in_ph2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> ph2_o);
  p_strobe_ends_ph2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !ph2_o);
  p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_busy_fall_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (dac_code_o == '0 && !ph1_o && !ph2_o && !acq_o));
  p_core_on_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> core_en_o);
  p_core_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && pdn_mode_i) |-> !core_en_o);

endmodule

bind sar_sequencer sar_sequencer_chk #(.WIDTH(WIDTH)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pdn_mode_i (pdn_mode_i),
  .dac_code_o (dac_code_o),
  .ph1_o      (ph1_o),
  .ph2_o      (ph2_o),
  .acq_o      (acq_o),
  .sample_o   (sample_o),
  .result_o   (result_o),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .core_en_o  (core_en_o)
);

// File: tb/test_sar_sequencer.sv
`timescale 1ns/1ps
module test_sar_sequencer;

  localparam int W        = 8;
  localparam int ACQ_CYC  = 4;
  localparam int PH_CYC   = 2;
  localparam int DEAD_CYC = 1;
  localparam int CONV_LEN = ACQ_CYC + W * (2 * DEAD_CYC + 2 * PH_CYC);

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i, cmp_i, pdn_mode_i;
  logic [W-1:0] dac_code_o, result_o;
  logic         ph1_o, ph2_o, acq_o, sample_o, done_o, busy_o, core_en_o;
  logic [W-1:0] vin;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // monitor state
  int  samp_cnt, acq_cnt;
  bit  p_ph1, p_ph2, p_acq, p_busy;

  always #4 clk = ~clk;

  // ideal comparator: high when the input code is at or above the DAC code
  assign cmp_i = (vin >= dac_code_o);

  sar_sequencer #(.WIDTH(W), .ACQ_CYC(ACQ_CYC), .PH_CYC(PH_CYC), .DEAD_CYC(DEAD_CYC))
  i_sar_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .pdn_mode_i(pdn_mode_i), .dac_code_o(dac_code_o), .ph1_o(ph1_o),
    .ph2_o(ph2_o), .acq_o(acq_o), .sample_o(sample_o), .result_o(result_o),
    .done_o(done_o), .busy_o(busy_o), .core_en_o(core_en_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_trial(input int v, input int k);
    int b;
    b = W - 1 - k;
    return ((v >> (b + 1)) << (b + 1)) | (1 << b);
  endfunction

  // cycle monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o && !p_busy) begin
        samp_cnt = 0;
        acq_cnt  = 0;
      end
      if (ph1_o && ph2_o) chk(1'b0, "R3 overlap", 1, 0);
      if ((p_ph1 && ph2_o) || (p_ph2 && ph1_o)) chk(1'b0, "R3 dead cycle", 1, 0);
      if (p_acq && !acq_o) chk(!ph1_o && !ph2_o, "R2 isolation", int'(ph1_o || ph2_o), 0);
      if (acq_o) acq_cnt++;
      if (sample_o) begin
        chk(ph2_o, "R5 strobe in compare phase", int'(ph2_o), 1);
        chk(int'(dac_code_o) == exp_trial(int'(vin), samp_cnt), "R4 trial code",
            int'(dac_code_o), exp_trial(int'(vin), samp_cnt));
        samp_cnt++;
      end
      if (busy_o && !core_en_o) chk(1'b0, "R9 core enable while busy", 0, 1);
      p_ph1  = ph1_o;
      p_ph2  = ph2_o;
      p_acq  = acq_o;
      p_busy = busy_o;
    end else begin
      p_ph1 = 0; p_ph2 = 0; p_acq = 0; p_busy = 0;
      samp_cnt = 0; acq_cnt = 0;
    end
  end

  // mode: 0 plain, 1 start pulse mid conversion, 2 start in last busy cycle
  task automatic run_conv(input logic [W-1:0] v, input int mode);
    int len;
    @(negedge clk);
    vin     = v;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(acq_o && busy_o, "R2 acquire in first busy cycle", int'(acq_o), 1);
    len = 0;
    while (busy_o && len < 4 * CONV_LEN) begin
      start_i = ((mode == 1 && len == 10) || (mode == 2 && len == CONV_LEN - 1));
      len++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(len == CONV_LEN, "R7 busy length", len, CONV_LEN);
    chk(done_o, "R7 done with busy fall", int'(done_o), 1);
    chk(result_o == v, "R6 result", int'(result_o), int'(v));
    chk(samp_cnt == W, "R5 strobe count", samp_cnt, W);
    chk(acq_cnt == ACQ_CYC, "R2 acquire width", acq_cnt, ACQ_CYC);
    @(negedge clk);
    chk(!done_o, "R7 done single cycle", int'(done_o), 0);
    if (mode != 0) begin
      chk(!busy_o, "R8 no restart from busy start", int'(busy_o), 0);
      chk(result_o == v, "R8 result kept", int'(result_o), int'(v));
    end
    chk(dac_code_o == '0 && !ph1_o && !ph2_o && !acq_o, "R10 idle quiet",
        int'(dac_code_o), 0);
  endtask

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'h5A12_0C07));
    rst_n = 1'b0; start_i = 1'b0; pdn_mode_i = 1'b1; vin = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !acq_o && !ph1_o && !ph2_o && !sample_o,
        "R1 reset controls", int'(busy_o), 0);
    chk(dac_code_o == '0 && result_o == '0, "R1 reset data", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && result_o == '0, "R1 after release", int'(busy_o), 0);
    chk(!core_en_o, "R9 idle powered down", int'(core_en_o), 0);
    pdn_mode_i = 1'b0;
    @(negedge clk);
    chk(core_en_o, "R9 idle powered up", int'(core_en_o), 1);

    // directed corners
    run_conv(8'd0, 0);
    run_conv(8'd255, 0);
    run_conv(8'd128, 0);
    run_conv(8'd127, 0);
    run_conv(8'd1, 1);
    run_conv(8'd254, 2);

    // conversion with power-down requested; core stays on while busy
    pdn_mode_i = 1'b1;
    run_conv(8'h5A, 0);
    chk(!core_en_o, "R9 powered down after done", int'(core_en_o), 0);
    held = result_o;
    vin = 8'h11;
    repeat (5) @(negedge clk);
    chk(result_o == held, "R6 result holds while idle", int'(result_o), int'(held));
    pdn_mode_i = 1'b0;

    // exhaustive sweep of every input code
    for (int c = 0; c < 256; c++) run_conv(W'(c), 0);

    // random codes, random start interference and power mode
    for (int n = 0; n < 60; n++) begin
      pdn_mode_i = 1'($urandom_range(0, 1));
      run_conv(W'($urandom_range(0, 255)), $urandom_range(0, 2));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule